// File: doc/BRIEF.md
# Microcode next-address sequencer

This block holds the micro-program counter of a microcoded 16-bit core and picks the address of the next microinstruction every clock. Its output drives the address port of a microcode ROM. Each ROM word returns a two-bit transfer kind, a 9-bit target and a yield flag. The sequencer also sees the fetched opcode byte, the three-bit reg field of the ModR/M byte, and the event lines of the core. Those lines are a synchronous reset, a non-maskable request, a maskable request, a single-step trap and a divide-error pulse.

The word that fetches opcodes carries the yield flag. It is the only place where pending requests can redirect the flow. When nothing is pending there, the raw opcode byte becomes the next address, so every opcode owns one entry word in the low 256 locations. A dispatch transfer adds the reg field to a base address, so one opcode can fan out to eight neighbouring words. Reset, the traps and the interrupts enter at fixed addresses. A stall input freezes the sequencer while the bus unit is busy.

Top module: `uaddr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0x129 on that edge, whatever the other inputs are. This includes `stall`.
- R2: With `rst` low and `stall` high, `upc` keeps its value. Every other input is ignored, including `div_err`.
- R3: Transfer kind 0 (sequential) loads `upc + 1`, modulo 512.
- R4: Transfer kind 1 (absolute) loads `target`.
- R5: Transfer kind 2 (opcode) loads the opcode byte zero-extended to 9 bits.
- R6: Transfer kind 3 (dispatch) loads `target + modrm_reg` modulo 512.
- R7: When `yield` is high and any request is pending, the next address is a vector, whatever the transfer kind is. NMI goes to 0x12A, single-step to 0x12C and IRQ to 0x12B. The priority order is NMI, then single-step, then IRQ.
- R8: When `yield` is low, the pending NMI, IRQ and single-step lines have no effect on the next address.
- R9: A `div_err` pulse with `rst` and `stall` low loads 0x101. This takes priority over yield and over every transfer kind.
- R10: The fetch word sits at 0x100. An absolute jump to 0x100 followed by a yield with nothing pending reaches the opcode entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold current address |
| nmi_req | input | 1 | Non-maskable request pending |
| irq_req | input | 1 | Maskable request pending |
| step_trap | input | 1 | Single-step trap pending |
| div_err | input | 1 | Divide-error pulse |
| yield_en | input | 1 | Yield flag of current microinstruction |
| jump_kind | input | 2 | 0 sequential, 1 absolute, 2 opcode, 3 dispatch |
| target | input | 9 | Jump target or dispatch base |
| opcode | input | 8 | Fetched opcode byte |
| modrm_reg | input | 3 | ModR/M reg field |
| upc | output | 9 | Current micro-address |

## Verification
The assertions check on every cycle the reset vector, the stall hold, sequential increment, opcode entry, divide-error entry and the NMI winning at a yield. Each of these is a property of one clock step. The bench scenarios show what single-cycle properties cannot cover well. These are the full priority ladder with several requests at once, pending requests ignored away from a yield, dispatch and sequential wrap at the top of the address space, and the fetch-then-dispatch flow through 0x100.

// File: rtl/uaddr_seq.sv
module uaddr_seq #(
  parameter int AW = 9,
  parameter int OW = 8,
  parameter int RW = 3,
  parameter logic [AW-1:0] RESET_VEC = 9'h129,
  parameter logic [AW-1:0] NMI_VEC   = 9'h12A,
  parameter logic [AW-1:0] IRQ_VEC   = 9'h12B,
  parameter logic [AW-1:0] STEP_VEC  = 9'h12C,
  parameter logic [AW-1:0] DIV_VEC   = 9'h101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          nmi_req,
  input  logic          irq_req,
  input  logic          step_trap,
  input  logic          div_err,
  input  logic          yield_en,
  input  logic [1:0]    jump_kind,
  input  logic [AW-1:0] target,
  input  logic [OW-1:0] opcode,
  input  logic [RW-1:0] modrm_reg,
  output logic [AW-1:0] upc
);
  localparam logic [1:0] K_SEQ = 2'd0, K_ABS = 2'd1, K_OPC = 2'd2, K_DSP = 2'd3;

  logic [AW-1:0] flow_addr, vec_addr, nxt;
  logic          take_vec;

  assign take_vec = yield_en & (nmi_req | irq_req | step_trap);
  assign vec_addr = nmi_req ? NMI_VEC : (step_trap ? STEP_VEC : IRQ_VEC);

  always_comb begin
    unique case (jump_kind)
      K_SEQ:   flow_addr = upc + AW'(1);
      K_ABS:   flow_addr = target;
      K_OPC:   flow_addr = AW'(opcode);
      K_DSP:   flow_addr = target + AW'(modrm_reg);
      default: flow_addr = upc;
    endcase
  end

  assign nxt = div_err ? DIV_VEC : (take_vec ? vec_addr : flow_addr);

  always_ff @(posedge clk) begin
    if (rst)         upc <= RESET_VEC;
    else if (!stall) upc <= nxt;
  end
endmodule

module uaddr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       stall,
  input logic       nmi_req,
  input logic       irq_req,
  input logic       step_trap,
  input logic       div_err,
  input logic       yield_en,
  input logic [1:0] jump_kind,
  input logic [7:0] opcode,
  input logic [8:0] upc
);
  logic rst_q;
  logic idle_evt;
  assign idle_evt = !div_err && !(yield_en && (nmi_req || irq_req || step_trap));

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      a_r1_reset_vec: assert (upc == 9'h129);
    end
  end

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(upc));

  a_r3_seq_inc: assert property (@(posedge clk) disable iff (rst)
    (!stall && idle_evt && jump_kind == 2'd0) |=> upc == $past(upc) + 9'd1);

  a_r5_opcode_entry: assert property (@(posedge clk) disable iff (rst)
    (!stall && idle_evt && jump_kind == 2'd2) |=> upc == {1'b0, $past(opcode)});

  a_r7_nmi_first: assert property (@(posedge clk) disable iff (rst)
    (!stall && !div_err && yield_en && nmi_req) |=> upc == 9'h12A);

  a_r9_div_entry: assert property (@(posedge clk) disable iff (rst)
    (!stall && div_err) |=> upc == 9'h101);
endmodule

bind uaddr_seq uaddr_seq_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .nmi_req(nmi_req), .irq_req(irq_req),
  .step_trap(step_trap), .div_err(div_err), .yield_en(yield_en),
  .jump_kind(jump_kind), .opcode(opcode), .upc(upc)
);

// File: tb/uaddr_seq_bench.sv
module uaddr_seq_bench;
  logic clk = 0, rst, stall, nmi_req, irq_req, step_trap, div_err, yield_en;
  logic [1:0] jump_kind;
  logic [8:0] target;
  logic [7:0] opcode;
  logic [2:0] modrm_reg;
  logic [8:0] upc;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  uaddr_seq u_uaddr_seq (.*);

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (upc !== e) begin
        errors++;
        $display("FAIL %s: upc=%h expected=%h", t, upc, e);
      end
    end
  end

  task automatic idle();
    rst = 0; stall = 0; nmi_req = 0; irq_req = 0; step_trap = 0; div_err = 0;
    yield_en = 0; jump_kind = 2'd0; target = '0; opcode = '0; modrm_reg = '0;
  endtask

  task automatic tick(input logic [8:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  initial begin
    idle();
    @(negedge clk); #1;
    rst = 1; nmi_req = 1; yield_en = 1; jump_kind = 2'd1; target = 9'h055;
    tick(9'h129, "R1 reset overrides");
    idle(); tick(9'h12A, "R3 seq after reset");
    tick(9'h12B, "R3 seq again");
    jump_kind = 2'd1; target = 9'h100; tick(9'h100, "R4 absolute to fetch");
    jump_kind = 2'd2; yield_en = 1; opcode = 8'h80;
    tick(9'h080, "R10 yield none pending -> opcode");
    jump_kind = 2'd3; yield_en = 0; target = 9'h1A0; modrm_reg = 3'd5;
    tick(9'h1A5, "R6 dispatch base+reg");
    target = 9'h1FF; modrm_reg = 3'd7; tick(9'h006, "R6 dispatch wrap");
    jump_kind = 2'd0; nmi_req = 1; irq_req = 1; step_trap = 1;
    tick(9'h007, "R8 pending ignored without yield");
    idle(); jump_kind = 2'd1; target = 9'h100; tick(9'h100, "R4 absolute");
    jump_kind = 2'd2; yield_en = 1; irq_req = 1; tick(9'h12B, "R7 irq vector");
    idle(); jump_kind = 2'd1; target = 9'h100; tick(9'h100, "R4 absolute");
    jump_kind = 2'd2; yield_en = 1; irq_req = 1; step_trap = 1;
    tick(9'h12C, "R7 step over irq");
    idle(); jump_kind = 2'd2; yield_en = 1; nmi_req = 1; irq_req = 1; step_trap = 1;
    tick(9'h12A, "R7 nmi over all");
    idle(); stall = 1; jump_kind = 2'd1; target = 9'h055; div_err = 1;
    tick(9'h12A, "R2 stall holds");
    tick(9'h12A, "R2 stall holds again");
    stall = 0; tick(9'h101, "R9 div error entry");
    idle(); jump_kind = 2'd1; target = 9'h1FF; tick(9'h1FF, "R4 absolute top");
    jump_kind = 2'd0; tick(9'h000, "R3 seq wrap");
    jump_kind = 2'd1; target = 9'h0C0; div_err = 1; yield_en = 1; nmi_req = 1;
    tick(9'h101, "R9 div over yield");
    idle(); stall = 1; rst = 1; tick(9'h129, "R1 reset during stall");
    idle(); jump_kind = 2'd2; opcode = 8'hFF; tick(9'h0FF, "R5 opcode entry");
    idle();
    @(negedge clk); #1;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule